// File: doc/BRIEF.md
# Real-Time Clock Oscillator-Halt and Alarm Status Flags

This block keeps two sticky status bits for a real-time clock. The first, the oscillator-halt flag, tells the host that the crystal oscillator stopped at some point. Examples are power-up or a supply dip. Once this flag is set, the time and calendar counts are not trustworthy until the host has rewritten them and cleared the flag. The flag samples the oscillator-stop detector only while the host is not accessing the chip. During an access it is frozen. A write of any value to the first control register, at address 0xE, clears it, but only while the oscillator is running.

The second flag records an alarm match. It is set only when the alarm is enabled, and it drives an active-low interrupt pin. The host clears it by writing a 0 to its bit in the second control register. Writing a 1 to that bit leaves the flag unchanged.

The alarm comparator and the analog oscillator-stop detector sit outside this block. The block receives their results as single-bit inputs.

Top module: `rtc_status_flags`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, the oscillator-halt flag reads 1, the alarm flag reads 0 and the interrupt pin reads 1.
- R2: When the host-access input is low and the oscillator-stop input is high at a clock edge, the oscillator-halt flag is 1 after that edge.
- R3: The oscillator-halt flag stays at 1 after the oscillator-stop input returns low, for as long as no clearing write occurs.
- R4: While the host-access input is high, the oscillator-stop input has no effect, and the oscillator-halt flag keeps its value.
- R5: A write strobe with address 0xE, any data and the oscillator-stop input low clears the oscillator-halt flag at the next edge. A write to any other address does not clear it. A write while the oscillator-stop input is high does not clear it either.
- R6: An alarm-match pulse sets the alarm flag at the next edge only if the alarm-enable input is 1 in the same cycle. A match with the enable at 0 leaves the flag unchanged.
- R7: The interrupt pin is registered. After each edge it is low exactly when the alarm flag is 1 and the alarm-enable input was 1 before that edge.
- R8: A write to address 0xF with data bit 2 equal to 0 clears the alarm flag. A write there with bit 2 equal to 1 leaves the flag unchanged.
- R9: When a set event and a clear write for the same flag happen in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_active_i | input | 1 | High while the host is accessing the chip; freezes the oscillator-halt flag |
| osc_stopped_i | input | 1 | Oscillator-stop detector result, high while the oscillator is halted |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| alarm_hit_i | input | 1 | Alarm comparator match pulse |
| alarm_en_i | input | 1 | Alarm enable |
| osc_halt_o | output | 1 | Oscillator-halt flag |
| alarm_flag_o | output | 1 | Alarm flag |
| irq_n_o | output | 1 | Active-low alarm interrupt |

## Verification
The assertions check on every cycle the properties that relate one edge to the next:
- the halt flag is set by an unmasked stop, and it stays frozen during a host access;
- the clear write succeeds when nothing competes with it;
- the alarm flag sets on an enabled match, and it never rises without such a match;
- the interrupt pin matches the registered flag gated by the enable.

Some behaviour only the bench's scenarios can show. The first is stickiness over long idle stretches. The second is that writes to the wrong address or with the wrong data bit are ignored. The third is the set-over-clear priority under every combination of concurrent inputs. The bench sweeps every combination of the inputs, starting from the flag states left by the previous steps. It checks all three outputs against an arithmetic model after each step.

// File: rtl/rtc_flag_pkg.sv
package rtc_flag_pkg;
  typedef struct packed {
    logic halt_clr;   // clear request for the oscillator-halt flag
    logic alarm_clr;  // clear request for the alarm flag
  } wr_strobes_t;
endpackage

// File: rtl/rtcf_wr_decode.sv
module rtcf_wr_decode #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HALT_ADDR = 14,
  parameter int ALM_ADDR  = 15,
  parameter int ALM_BIT   = 2
) (
  input  logic                     wr_en_i,
  input  logic [ADDR_W-1:0]        wr_addr_i,
  input  logic [DATA_W-1:0]        wr_data_i,
  output rtc_flag_pkg::wr_strobes_t strb_o
);
  localparam logic [ADDR_W-1:0] HaltA = ADDR_W'(HALT_ADDR);
  localparam logic [ADDR_W-1:0] AlmA  = ADDR_W'(ALM_ADDR);

  always_comb begin
    strb_o.halt_clr  = wr_en_i && (wr_addr_i == HaltA);
    strb_o.alarm_clr = wr_en_i && (wr_addr_i == AlmA) && !wr_data_i[ALM_BIT];
  end
endmodule

// File: rtl/rtcf_halt_flag.sv
module rtcf_halt_flag (
  input  logic clk,
  input  logic rst,
  input  logic host_active_i,
  input  logic osc_stopped_i,
  input  logic clr_req_i,
  output logic halt_o
);
  logic set_ev, clr_ev;

  assign set_ev = !host_active_i && osc_stopped_i;
  assign clr_ev = clr_req_i && !osc_stopped_i;

  always_ff @(posedge clk) begin
    if (rst)         halt_o <= 1'b1;
    else if (set_ev) halt_o <= 1'b1;
    else if (clr_ev) halt_o <= 1'b0;
  end

  a_r2_stop_sets: assert property (@(posedge clk) disable iff (rst)
    (!host_active_i && osc_stopped_i) |=> halt_o);

  a_r4_frozen_in_access: assert property (@(posedge clk) disable iff (rst)
    (host_active_i && !clr_req_i) |=> $stable(halt_o));

  a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
    (clr_req_i && !osc_stopped_i) |=> !halt_o);
endmodule

// File: rtl/rtcf_alarm_flag.sv
module rtcf_alarm_flag (
  input  logic clk,
  input  logic rst,
  input  logic alarm_hit_i,
  input  logic alarm_en_i,
  input  logic clr_req_i,
  output logic flag_o,
  output logic irq_n_o
);
  logic set_ev, flag_nxt;

  assign set_ev = alarm_hit_i && alarm_en_i;

  always_comb begin
    flag_nxt = flag_o;
    if (clr_req_i) flag_nxt = 1'b0;
    if (set_ev)    flag_nxt = 1'b1;  // set wins over clear
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      irq_n_o <= 1'b1;
    end else begin
      flag_o  <= flag_nxt;
      irq_n_o <= !(flag_nxt && alarm_en_i);
    end
  end

  a_r6_enabled_hit_sets: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag_o);

  a_r6_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
    (!set_ev && !flag_o) |=> !flag_o);

  a_r7_irq_tracks_flag: assert property (@(posedge clk) disable iff (rst)
    irq_n_o == !(flag_o && $past(alarm_en_i)));
endmodule

// File: rtl/rtc_status_flags.sv
module rtc_status_flags #(
  parameter int ADDR_W    = 4,
  parameter int DATA_W    = 8,
  parameter int HALT_ADDR = 14,
  parameter int ALM_ADDR  = 15,
  parameter int ALM_BIT   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_active_i,
  input  logic              osc_stopped_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              alarm_hit_i,
  input  logic              alarm_en_i,
  output logic              osc_halt_o,
  output logic              alarm_flag_o,
  output logic              irq_n_o
);
  rtc_flag_pkg::wr_strobes_t strb;

  rtcf_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HALT_ADDR(HALT_ADDR),
    .ALM_ADDR(ALM_ADDR), .ALM_BIT(ALM_BIT)
  ) u_dec (
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .strb_o(strb)
  );

  rtcf_halt_flag u_halt (
    .clk(clk), .rst(rst), .host_active_i(host_active_i),
    .osc_stopped_i(osc_stopped_i), .clr_req_i(strb.halt_clr),
    .halt_o(osc_halt_o)
  );

  rtcf_alarm_flag u_alarm (
    .clk(clk), .rst(rst), .alarm_hit_i(alarm_hit_i), .alarm_en_i(alarm_en_i),
    .clr_req_i(strb.alarm_clr), .flag_o(alarm_flag_o), .irq_n_o(irq_n_o)
  );

  a_r1_reset_state: assert property (@(posedge clk)
    $past(rst) |-> (osc_halt_o && !alarm_flag_o && irq_n_o));
endmodule

// File: tb/sim_rtc_status_flags.sv
module sim_rtc_status_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_active, osc_stopped, wr_en, alarm_hit, alarm_en;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  logic osc_halt, alarm_flag, irq_n;

  int n_vec = 0;
  int n_bad = 0;
  logic m_halt, m_alarm, m_irqn;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_status_flags u0 (
    .clk(clk), .rst(rst), .host_active_i(host_active), .osc_stopped_i(osc_stopped),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .alarm_hit_i(alarm_hit), .alarm_en_i(alarm_en),
    .osc_halt_o(osc_halt), .alarm_flag_o(alarm_flag), .irq_n_o(irq_n)
  );

  task automatic check(input logic act, input logic exp, input string what);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", what, act, exp, $time);
    end
  endtask

  task automatic step(input logic ha, input logic os, input logic we, input logic [3:0] a,
                      input logic [7:0] d, input logic hit, input logic en, input string tag);
    logic set_h, clr_h, set_a, clr_a;
    host_active = ha; osc_stopped = os; wr_en = we; wr_addr = a; wr_data = d;
    alarm_hit = hit; alarm_en = en;
    set_h = !ha && os;
    clr_h = we && (a == 4'hE) && !os;
    set_a = hit && en;
    clr_a = we && (a == 4'hF) && !d[2];
    if (set_h) m_halt = 1'b1; else if (clr_h) m_halt = 1'b0;
    if (set_a) m_alarm = 1'b1; else if (clr_a) m_alarm = 1'b0;
    m_irqn = !(m_alarm && en);
    @(posedge clk); #1;
    check(osc_halt,   m_halt,  {tag, " R2/R3/R4/R5 halt flag"});
    check(alarm_flag, m_alarm, {tag, " R6/R8/R9 alarm flag"});
    check(irq_n,      m_irqn,  {tag, " R7 irq pin"});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [3:0] addrs [4];
    logic [7:0] datas [2];
    addrs[0] = 4'hE; addrs[1] = 4'hF; addrs[2] = 4'h0; addrs[3] = 4'h7;
    datas[0] = 8'hFB; datas[1] = 8'h04;
    host_active = 0; osc_stopped = 0; wr_en = 0; wr_addr = 0; wr_data = 0;
    alarm_hit = 0; alarm_en = 0;
    repeat (3) @(posedge clk);
    #1;
    check(osc_halt, 1'b1, "R1 reset halt");
    check(alarm_flag, 1'b0, "R1 reset alarm");
    check(irq_n, 1'b1, "R1 reset irq");
    rst = 1'b0;
    m_halt = 1'b1; m_alarm = 1'b0; m_irqn = 1'b1;
    // R5: write to the control register at 0xE clears the halt flag
    step(1, 0, 1, 4'hE, 8'h00, 0, 0, "R5 clear");
    step(0, 0, 1, 4'h3, 8'h00, 0, 0, "R5 wrong addr");
    // R4: stop ignored during host access
    step(1, 1, 0, 4'h0, 8'h00, 0, 0, "R4 masked stop");
    // R2 then R3 sticky
    step(0, 1, 0, 4'h0, 8'h00, 0, 0, "R2 stop");
    for (int i = 0; i < 5; i++) step(0, 0, 0, 4'h0, 8'h00, 0, 0, "R3 sticky");
    step(1, 1, 1, 4'hE, 8'h00, 0, 0, "R5 no clear while stopped");
    // R6 enable gating, R7 irq, R8 clears, R9 priority
    step(0, 0, 0, 4'h0, 8'h00, 1, 0, "R6 disabled hit");
    step(0, 0, 0, 4'h0, 8'h00, 1, 1, "R6 enabled hit");
    step(0, 0, 0, 4'h0, 8'h00, 0, 0, "R7 enable dropped");
    step(0, 0, 1, 4'hF, 8'h04, 0, 1, "R8 write one ignored");
    step(0, 0, 1, 4'hF, 8'hFB, 1, 1, "R9 set over clear");
    step(0, 0, 1, 4'hF, 8'hFB, 0, 1, "R8 write zero clears");
    // Near-exhaustive sweep over all input combinations, two orders
    for (int pass = 0; pass < 2; pass++)
      for (int v = 0; v < 256; v++) begin
        int k;
        k = pass ? (255 - v) : ((v * 37) & 255);
        step(k[0], k[1], k[2], addrs[k[4:3]], datas[k[5]], k[6], k[7], "sweep");
      end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule